// File: doc/BRIEF.md
# Command-Word Register Bridge

This block lets a host reach a small set of 8-bit controller registers through one 64-bit command word. The host writes the word with its go flag set; the word names an operation class, a direction, a 3-bit selector and a data byte. The bridge holds the word and stays busy for a fixed number of cycles. It then performs the internal write or read, clears the go flag and, for a read, puts the fetched byte in the low eight bits. The host reads the command word back and polls the go flag to learn that the access is done.

The target registers are modelled simply: a data byte, a control byte, a status byte driven by the control byte, a clock-control byte, a clock-period byte and an eight-entry extended bank. Selector 3 reaches clock control on a write but status on a read. Selector 7 is a soft reset of the byte engine.

Top module: `cmd_word_bridge`

## Requirements
- R1: After reset the command readback is all zeros, `err_o` is 0, `clk_ctl_o` and `clk_period_o` are 0, and a status read (selector 3, read flag set) returns 0xF8, the idle code.
- R2: A write with bit 63 set, made while bit 63 of the readback is clear, is accepted. Bit 63 of the readback reads 1 from the next cycle and clears exactly LATENCY cycles (default 4) after the accepting edge.
- R3: With bits 59:58 = 00, the host writes bits 7:0 to the selected register when bit 56 is 0 and reads it when bit 56 is 1: selector 1 is the data register and selector 2 the control register. A completed read returns the byte in bits 7:0 of the readback.
- R4: Selector 3 with bits 59:58 = 00 writes the clock-control register, seen on `clk_ctl_o`, but reads the status register; the two are distinct storage.
- R5: A control write with bit 5 set moves status to 0x08. A write to selector 7 returns status to 0xF8 and clears the data and control registers, and it leaves the clock settings unchanged.
- R6: With bits 59:58 = 11, the access targets an eight-entry extended bank indexed by bits 34:32, independent of the core registers.
- R7: With bits 59:58 = 10, a write loads the clock-period register, seen on `clk_period_o`, and a read returns it; clock control is untouched.
- R8: A command written while bit 63 of the readback is set is ignored, and the sticky `err_o` goes to 1 and stays 1 until reset.
- R9: Every undefined bit (62:60, 57, 55:35, 31:8) reads back as zero, whatever the host wrote there.
- R10: Selectors 0, 4, 5 and 6 of the core class read as 0. A written word with bit 63 clear starts no access and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_wr | input | 1 | Host write strobe for the command word |
| cmd_wdata | input | 64 | Command word written by the host |
| cmd_rdata | output | 64 | Command word readback: go flag, fields, result byte |
| err_o | output | 1 | Sticky flag: a command arrived while busy |
| clk_ctl_o | output | 8 | Clock-control register, to the bus engine |
| clk_period_o | output | 8 | Clock-period register, to the bus engine |

## Verification
Commands are sent with every operation class (core, clock period, extended) and both directions. Each targets a selector whose write and read paths differ or coincide, so a wrong selector map shows up as a wrong byte or a changed clock output. Selector 3 is written and then read to separate clock control from status, and the extended bank is loaded at two indices and then read back to catch addressing or aliasing with the core data register. Completion is timed in cycles on every access. Junk in the undefined bits, a word without the go flag and a back-to-back command during busy show whether the bridge filters, ignores and flags what it should.

// File: rtl/cmd_bridge_pkg.sv
package cmd_bridge_pkg;
  localparam int WORD_W = 64;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  localparam int GO_BIT   = 63;
  localparam int OP_HI    = 59;
  localparam int OP_LO    = 58;
  localparam int RD_BIT   = 56;
  localparam int SEL_LO   = 32;

  localparam logic [WORD_W-1:0] DEF_MASK = 64'h8D00_0007_0000_00FF;

  localparam logic [BYTE_W-1:0] ST_IDLE  = 8'hF8;
  localparam logic [BYTE_W-1:0] ST_START = 8'h08;
  localparam int START_REQ_BIT = 5;

  typedef enum logic [2:0] {
    T_NONE, T_DATA, T_CTRL, T_CLKCTL, T_STATUS, T_SRST, T_PERIOD, T_EXT
  } tgt_t;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmd_bridge_pkg::*;
(
  input  logic [1:0]       op,
  input  logic             is_rd,
  input  logic [SEL_W-1:0] sel,
  output tgt_t             tgt
);
  always_comb begin
    tgt = T_NONE;
    unique case (op)
      2'b11: tgt = T_EXT;
      2'b10: tgt = T_PERIOD;
      default: begin
        case (sel)
          3'd1: tgt = T_DATA;
          3'd2: tgt = T_CTRL;
          3'd3: tgt = is_rd ? T_STATUS : T_CLKCTL;
          3'd7: tgt = is_rd ? T_NONE : T_SRST;
          default: tgt = T_NONE;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/core_regs.sv
module core_regs
  import cmd_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  tgt_t              tgt,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rbyte,
  output logic [BYTE_W-1:0] clk_ctl,
  output logic [BYTE_W-1:0] clk_period
);
  logic [BYTE_W-1:0] data_r, ctrl_r, stat_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_r     <= '0;
      ctrl_r     <= '0;
      stat_r     <= ST_IDLE;
      clk_ctl    <= '0;
      clk_period <= '0;
    end else if (we) begin
      case (tgt)
        T_DATA:   data_r <= wdata;
        T_CTRL: begin
          ctrl_r <= wdata;
          if (wdata[START_REQ_BIT]) stat_r <= ST_START;
        end
        T_CLKCTL: clk_ctl <= wdata;
        T_PERIOD: clk_period <= wdata;
        T_SRST: begin
          data_r <= '0;
          ctrl_r <= '0;
          stat_r <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (tgt)
      T_DATA:   rbyte = data_r;
      T_CTRL:   rbyte = ctrl_r;
      T_STATUS: rbyte = stat_r;
      T_PERIOD: rbyte = clk_period;
      default:  rbyte = '0;
    endcase
  end
endmodule

// File: rtl/ext_bank.sv
module ext_bank #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/cmd_word_bridge.sv
module cmd_word_bridge
  import cmd_bridge_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic [WORD_W-1:0] cmd_rdata,
  output logic              err_o,
  output logic [BYTE_W-1:0] clk_ctl_o,
  output logic [BYTE_W-1:0] clk_period_o
);
  // LATENCY must be at least 2 so the extended bank's registered read settles.
  localparam int CW = $clog2(LATENCY + 1);

  logic [WORD_W-1:0] cmd_q;
  logic [CW-1:0]     cnt;
  logic              busy, accept, finish, do_wr;
  logic [SEL_W-1:0]  sel;
  tgt_t              tgt;
  logic [BYTE_W-1:0] core_rbyte, ext_rbyte;

  assign busy   = cmd_q[GO_BIT];
  assign accept = cmd_wr && cmd_wdata[GO_BIT] && !busy;
  assign finish = busy && (cnt == '0);
  assign do_wr  = finish && !cmd_q[RD_BIT];
  assign sel    = cmd_q[SEL_LO +: SEL_W];

  cmd_decode u_dec (
    .op    (cmd_q[OP_HI:OP_LO]),
    .is_rd (cmd_q[RD_BIT]),
    .sel   (sel),
    .tgt   (tgt)
  );

  core_regs u_core (
    .clk        (clk),
    .rst        (rst),
    .we         (do_wr),
    .tgt        (tgt),
    .wdata      (cmd_q[BYTE_W-1:0]),
    .rbyte      (core_rbyte),
    .clk_ctl    (clk_ctl_o),
    .clk_period (clk_period_o)
  );

  ext_bank #(.AW(SEL_W), .DW(BYTE_W)) u_ext (
    .clk   (clk),
    .we    (do_wr && (tgt == T_EXT)),
    .addr  (sel),
    .wdata (cmd_q[BYTE_W-1:0]),
    .rdata (ext_rbyte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      cnt   <= '0;
      err_o <= 1'b0;
    end else begin
      if (cmd_wr && busy) err_o <= 1'b1;
      if (accept) begin
        cmd_q <= cmd_wdata & DEF_MASK;
        cnt   <= CW'(LATENCY - 1);
      end else if (finish) begin
        cmd_q[GO_BIT] <= 1'b0;
        if (cmd_q[RD_BIT])
          cmd_q[BYTE_W-1:0] <= (tgt == T_EXT) ? ext_rbyte : core_rbyte;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign cmd_rdata = cmd_q;
endmodule

// File: rtl/cmd_word_bridge_chk.sv
module cmd_word_bridge_chk
  import cmd_bridge_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_wr,
  input logic [WORD_W-1:0] cmd_wdata,
  input logic [WORD_W-1:0] cmd_rdata,
  input logic              err_o,
  input logic [BYTE_W-1:0] clk_ctl_o,
  input logic [BYTE_W-1:0] clk_period_o
);
  logic        busy;
  logic [31:0] age;
  assign busy = cmd_rdata[GO_BIT];

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (cmd_wr && cmd_wdata[GO_BIT] && !busy) age <= 32'd1;
    else if (busy && age != 32'(LATENCY)) age <= age + 32'd1;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_wdata[GO_BIT] && !busy) |=> busy);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && age < 32'(LATENCY)) |=> busy);
  p_done_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && age == 32'(LATENCY)) |=> !busy);
  p_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && busy) |=> err_o);
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  p_undef_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_rdata & ~DEF_MASK) == '0);
  p_clkctl_at_done_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_ctl_o) |-> $fell(busy));
  p_period_at_done_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_period_o) |-> $fell(busy));
endmodule

bind cmd_word_bridge cmd_word_bridge_chk #(.LATENCY(LATENCY)) u_chk (.*);

// File: tb/test_cmd_word_bridge.sv
module test_cmd_word_bridge;
  localparam int LAT = 4;
  localparam logic [63:0] MASK = 64'h8D00_0007_0000_00FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [63:0] cmd_wdata = '0;
  logic [63:0] cmd_rdata;
  logic        err_o;
  logic [7:0]  clk_ctl_o, clk_period_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cmd_word_bridge #(.LATENCY(LAT)) i_cmd_word_bridge (
    .clk, .rst, .cmd_wr, .cmd_wdata, .cmd_rdata, .err_o, .clk_ctl_o, .clk_period_o
  );

  function automatic logic [63:0] mk(input logic rd, input logic [1:0] op,
                                     input logic [2:0] sel, input logic [7:0] d);
    mk = '0;
    mk[63] = 1'b1;
    mk[59:58] = op;
    mk[56] = rd;
    mk[34:32] = sel;
    mk[7:0] = d;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [63:0] w, output logic [63:0] res, output int cyc);
    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 1'b0;
    cyc = 0;
    while (cmd_rdata[63] && cyc < 100) begin
      cyc++;
      @(negedge clk);
    end
    res = cmd_rdata;
  endtask

  task automatic rd_byte(input logic [1:0] op, input logic [2:0] sel, output logic [7:0] b);
    logic [63:0] r;
    int c;
    run_cmd(mk(1'b1, op, sel, 8'h00), r, c);
    b = r[7:0];
  endtask

  task automatic wr_byte(input logic [1:0] op, input logic [2:0] sel, input logic [7:0] d);
    logic [63:0] r;
    int c;
    run_cmd(mk(1'b0, op, sel, d), r, c);
  endtask

  task automatic t_reset;
    logic [7:0] b;
    check(cmd_rdata == '0, "R1 readback", cmd_rdata, '0);
    check(err_o == 1'b0, "R1 err", 64'(err_o), 0);
    check(clk_ctl_o == 8'h00 && clk_period_o == 8'h00, "R1 clock regs",
          {clk_ctl_o, clk_period_o}, 0);
    rd_byte(2'b00, 3'd3, b);
    check(b == 8'hF8, "R1 idle status", 64'(b), 64'hF8);
  endtask

  task automatic t_latency;
    logic [63:0] w, r;
    int c;
    w = mk(1'b0, 2'b00, 3'd1, 8'h5A);
    run_cmd(w, r, c);
    check(c == LAT, "R2 completion cycles", 64'(c), 64'(LAT));
    check(r == {1'b0, w[62:0]}, "R2 write readback", r, {1'b0, w[62:0]});
  endtask

  task automatic t_data_ctrl;
    logic [7:0] b;
    rd_byte(2'b00, 3'd1, b);
    check(b == 8'h5A, "R3 data read", 64'(b), 64'h5A);
    wr_byte(2'b00, 3'd2, 8'h41);
    rd_byte(2'b00, 3'd2, b);
    check(b == 8'h41, "R3 control read", 64'(b), 64'h41);
  endtask

  task automatic t_sel3;
    logic [7:0] b;
    wr_byte(2'b00, 3'd3, 8'h1B);
    check(clk_ctl_o == 8'h1B, "R4 clock control written", 64'(clk_ctl_o), 64'h1B);
    rd_byte(2'b00, 3'd3, b);
    check(b == 8'hF8, "R4 selector 3 reads status", 64'(b), 64'hF8);
  endtask

  task automatic t_start_srst;
    logic [7:0] b;
    wr_byte(2'b00, 3'd2, 8'h60);
    rd_byte(2'b00, 3'd3, b);
    check(b == 8'h08, "R5 start status", 64'(b), 64'h08);
    wr_byte(2'b00, 3'd7, 8'h00);
    rd_byte(2'b00, 3'd3, b);
    check(b == 8'hF8, "R5 soft reset status", 64'(b), 64'hF8);
    rd_byte(2'b00, 3'd2, b);
    check(b == 8'h00, "R5 soft reset control", 64'(b), 0);
    check(clk_ctl_o == 8'h1B, "R5 clock control kept", 64'(clk_ctl_o), 64'h1B);
  endtask

  task automatic t_ext;
    logic [7:0] b;
    wr_byte(2'b11, 3'd1, 8'hC3);
    wr_byte(2'b11, 3'd6, 8'h3C);
    rd_byte(2'b11, 3'd1, b);
    check(b == 8'hC3, "R6 extended index 1", 64'(b), 64'hC3);
    rd_byte(2'b11, 3'd6, b);
    check(b == 8'h3C, "R6 extended index 6", 64'(b), 64'h3C);
    rd_byte(2'b00, 3'd1, b);
    check(b == 8'h00, "R6 core data untouched", 64'(b), 0);
  endtask

  task automatic t_period;
    logic [7:0] b;
    wr_byte(2'b10, 3'd0, 8'h77);
    check(clk_period_o == 8'h77, "R7 period written", 64'(clk_period_o), 64'h77);
    check(clk_ctl_o == 8'h1B, "R7 clock control kept", 64'(clk_ctl_o), 64'h1B);
    rd_byte(2'b10, 3'd0, b);
    check(b == 8'h77, "R7 period read", 64'(b), 64'h77);
  endtask

  task automatic t_undef;
    logic [63:0] w, r;
    int c;
    w = mk(1'b0, 2'b00, 3'd1, 8'h99) | 64'h72FF_FFF8_FFFF_FF00;
    run_cmd(w, r, c);
    check((r & ~MASK) == '0, "R9 undefined bits zero", r & ~MASK, 0);
  endtask

  task automatic t_unused;
    logic [7:0] b;
    logic [63:0] w;
    rd_byte(2'b00, 3'd5, b);
    check(b == 8'h00, "R10 unused selector", 64'(b), 0);
    w = mk(1'b0, 2'b00, 3'd1, 8'hEE);
    w[63] = 1'b0;
    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(cmd_rdata[63] == 1'b0, "R10 no go flag no start", 64'(cmd_rdata[63]), 0);
    rd_byte(2'b00, 3'd1, b);
    check(b == 8'h99, "R10 no go flag no write", 64'(b), 64'h99);
  endtask

  task automatic t_busy;
    logic [7:0] b;
    check(err_o == 1'b0, "R8 err clear before", 64'(err_o), 0);
    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_wdata = mk(1'b0, 2'b00, 3'd1, 8'h11);
    @(negedge clk);
    cmd_wdata = mk(1'b0, 2'b00, 3'd1, 8'h22);
    @(negedge clk);
    cmd_wr = 1'b0;
    for (int i = 0; i < 20 && cmd_rdata[63]; i++) @(negedge clk);
    check(err_o == 1'b1, "R8 err raised", 64'(err_o), 1);
    rd_byte(2'b00, 3'd1, b);
    check(b == 8'h11, "R8 second command ignored", 64'(b), 64'h11);
    check(err_o == 1'b1, "R8 err sticky", 64'(err_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_data_ctrl();
    t_sel3();
    t_start_srst();
    t_ext();
    t_period();
    t_undef();
    t_unused();
    t_busy();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule